// File: doc/BRIEF.md
# Narrow Strobe Pulse Stretcher

This block turns a conversion-complete strobe from an analog converter into a trigger pulse of fixed length for a device off the chip. The strobe may last only a few tens of nanoseconds, which can be shorter than one period of the system clock. Sampling the strobe on a clock edge could therefore miss it.

The rising edge of the strobe sets a capture flop directly, with no clock involved. A two-stage synchronizer carries the flag into the clock domain. An edge detector then turns it into a start pulse one cycle long. The start pulse launches a counting one-shot, which holds the output high for a number of clock cycles set by the `width_cfg_i` input. When that input is zero, a parameter default applies: 240 cycles, which is 10 µs at 24 MHz.

The output starts a fixed three clock edges after the strobe. That gives at most one clock period of start jitter, which the external device tolerates. A strobe that arrives while a pulse is running is not lost without trace. It leaves the running pulse unchanged and sets a sticky overrun flag. Connect only the conversion-complete strobe to this block. The sample-done strobe of an averaging converter fires several times per result, and most of those firings come before the result is ready.

Top module: `pulse_stretch`

## Requirements
- R1: While `rst_n_i` is low at a rising clock edge, `pulse_o` and `overrun_o` are low after that edge.
- R2: A strobe high for less than one clock period produces one output pulse.
- R3: A strobe rising between clock edges E0 and E1 causes `pulse_o` to be low after E2 and high after E3. The output never rises without a prior strobe.
- R4: The pulse stays high for exactly N rising clock edges, where N is the value of `width_cfg_i` (1 to 2^CNT_W-1).
- R5: A `width_cfg_i` of zero gives a pulse of DEF_WIDTH cycles (240 by default).
- R6: `width_cfg_i` is taken on the edge where the pulse starts. Later changes do not alter the running pulse.
- R7: A strobe whose start event lands while `pulse_o` is high neither restarts nor lengthens the pulse, and it sets `overrun_o`.
- R8: `overrun_o` stays high once set, through later pulses, until reset.
- R9: One strobe gives exactly one pulse, even when the strobe stays high for several clock periods.
- R10: A strobe that rises and falls while reset is asserted produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Synchronous active-low reset (also holds the capture flop clear) |
| strobe_i | input | 1 | Raw conversion-complete strobe, asynchronous, possibly sub-cycle |
| width_cfg_i | input | CNT_W | Pulse length in clock cycles; 0 selects DEF_WIDTH |
| pulse_o | output | 1 | Stretched trigger pulse |
| overrun_o | output | 1 | Sticky flag: a strobe arrived while a pulse was running |

## Verification
The bench drives strobes of three kinds: sub-nanosecond slivers, which show that capture does not depend on a clock edge; strobes about one period long; and strobes many periods long, which show that a held-high input fires only once. Configured widths range from 1 up to the counter maximum, plus zero for the default. These separate an off-by-one counter from a correct one and confirm that the width is latched at start. A second strobe placed inside a running pulse checks that the pulse is not extended and that the overrun flag sets and then holds. Strobes issued during reset check that the capture stage is held clear.

// File: rtl/pulse_stretch_pkg.sv
`timescale 1ns/100ps
// Package: shared types for the pulse stretcher.
// Assumes: nothing beyond IEEE 1800-2017.
package pulse_stretch_pkg;

    // One-shot timer states
    typedef enum logic {
        OS_IDLE = 1'b0,
        OS_RUN  = 1'b1
    } os_state_t;

    // Number of synchronizer stages used by default
    localparam int SYNC_STAGES_DEF = 2;

endpackage

// File: rtl/pulse_stretch_sync.sv
`timescale 1ns/100ps
// Module: pulse_stretch_sync
// Multi-flop synchronizer that brings a level signal into clk_i's domain.
// Assumes: d_i changes no faster than a few clocks; STAGES >= 2.
module pulse_stretch_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] stage_q;

    // First stage samples the asynchronous level
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) stage_q[0] <= 1'b0;
        else          stage_q[0] <= d_i;
    end

    // Remaining stages form the settle chain
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk_i) begin
            if (!rst_n_i) stage_q[g] <= 1'b0;
            else          stage_q[g] <= stage_q[g-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pulse_stretch_catch.sv
`timescale 1ns/100ps
// Module: pulse_stretch_catch
// Catches a strobe of any width with a flop clocked by the strobe itself.
// Synchronizes the caught flag, emits a one-cycle start pulse on its rising
// edge and clears the catch flop once the synchronized copy is seen.
// Assumes: strobes are spaced by more than about STAGES+4 clock cycles. A
// strobe rising while the clear is held (a few cycles after a start) is lost.
module pulse_stretch_catch #(
    parameter int STAGES = pulse_stretch_pkg::SYNC_STAGES_DEF
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic strobe_i,
    output logic start_o
);
    logic caught_q;
    logic caught_sync;
    logic sync_dly_q;
    logic clear_q;
    logic caught_clr;

    // Catch flop is held clear during reset or while the handshake clears it
    assign caught_clr = (!rst_n_i) | clear_q;

    // Strobe rising edge sets the flag regardless of the system clock
    always_ff @(posedge strobe_i or posedge caught_clr) begin
        if (caught_clr) caught_q <= 1'b0;
        else            caught_q <= 1'b1;
    end

    // Bring the caught flag into the clock domain
    pulse_stretch_sync #(
        .STAGES (STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .d_i     (caught_q),
        .q_o     (caught_sync)
    );

    // Delay the synchronized flag by one cycle for edge detection
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) sync_dly_q <= 1'b0;
        else          sync_dly_q <= caught_sync;
    end

    // Hold the catch flop clear until the synchronized copy drops again
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) clear_q <= 1'b0;
        else          clear_q <= caught_sync;
    end

    assign start_o = caught_sync & ~sync_dly_q;
endmodule

// File: rtl/pulse_stretch_timer.sv
`timescale 1ns/100ps
// Module: pulse_stretch_timer
// Counting one-shot. On start_i while idle it raises pulse_o on the next
// edge and holds it for the latched width. A start while running only sets
// the sticky overrun flag.
// Assumes: start_i is a single-cycle pulse synchronous to clk_i.
module pulse_stretch_timer
    import pulse_stretch_pkg::*;
#(
    parameter int CNT_W     = 9,
    parameter int DEF_WIDTH = 240
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             start_i,
    input  logic [CNT_W-1:0] width_cfg_i,
    output logic             pulse_o,
    output logic             overrun_o
);
    localparam logic [CNT_W-1:0] DEF_W_L = CNT_W'(DEF_WIDTH);
    localparam logic [CNT_W-1:0] ONE_L   = CNT_W'(1);

    os_state_t        state_q;
    logic [CNT_W-1:0] remain_q;
    logic [CNT_W-1:0] eff_width;
    logic             overrun_q;

    // Select the configured width or the default when zero
    always_comb begin
        eff_width = (width_cfg_i == '0) ? DEF_W_L : width_cfg_i;
    end

    // State and remaining-cycle counter of the one-shot
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            state_q  <= OS_IDLE;
            remain_q <= '0;
        end else begin
            case (state_q)
                OS_IDLE: begin
                    if (start_i) begin
                        state_q  <= OS_RUN;
                        remain_q <= eff_width - ONE_L;
                    end
                end
                OS_RUN: begin
                    if (remain_q == '0) state_q  <= OS_IDLE;
                    else                remain_q <= remain_q - ONE_L;
                end
                default: state_q <= OS_IDLE;
            endcase
        end
    end

    // Sticky record of a start that hit a running pulse
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)                           overrun_q <= 1'b0;
        else if (start_i && state_q == OS_RUN)  overrun_q <= 1'b1;
    end

    assign pulse_o   = (state_q == OS_RUN);
    assign overrun_o = overrun_q;
endmodule

// File: rtl/pulse_stretch.sv
`timescale 1ns/100ps
// Module: pulse_stretch (top)
// Stretches a possibly sub-cycle conversion-complete strobe into a trigger
// pulse of width_cfg_i clock cycles (DEF_WIDTH when zero).
// Assumes: one clock domain; start jitter of up to one clock is acceptable.
module pulse_stretch #(
    parameter int CNT_W       = 9,
    parameter int DEF_WIDTH   = 240,
    parameter int SYNC_STAGES = pulse_stretch_pkg::SYNC_STAGES_DEF
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             strobe_i,
    input  logic [CNT_W-1:0] width_cfg_i,
    output logic             pulse_o,
    output logic             overrun_o
);
    logic start_w;

    // Asynchronous capture, synchronization and start-pulse generation
    pulse_stretch_catch #(
        .STAGES (SYNC_STAGES)
    ) u_catch (
        .clk_i    (clk_i),
        .rst_n_i  (rst_n_i),
        .strobe_i (strobe_i),
        .start_o  (start_w)
    );

    // Counting one-shot with overrun detection
    pulse_stretch_timer #(
        .CNT_W     (CNT_W),
        .DEF_WIDTH (DEF_WIDTH)
    ) u_timer (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_i),
        .start_i     (start_w),
        .width_cfg_i (width_cfg_i),
        .pulse_o     (pulse_o),
        .overrun_o   (overrun_o)
    );
endmodule

// File: rtl/pulse_stretch_chk.sv
`timescale 1ns/100ps
// Module: pulse_stretch_chk
// Property checker bound to pulse_stretch; observes ports and the start pulse.
module pulse_stretch_chk #(
    parameter int CNT_W     = 9,
    parameter int DEF_WIDTH = 240
) (
    input logic             clk_i,
    input logic             rst_n_i,
    input logic             start_i,
    input logic [CNT_W-1:0] width_cfg_i,
    input logic             pulse_i,
    input logic             overrun_i
);
    logic [CNT_W:0] run_len_q;
    logic [CNT_W:0] want_len_q;

    // Track expected and observed length of the current pulse
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            run_len_q  <= '0;
            want_len_q <= '0;
        end else begin
            if (start_i && !pulse_i)
                want_len_q <= (width_cfg_i == '0) ? (CNT_W+1)'(DEF_WIDTH)
                                                  : {1'b0, width_cfg_i};
            if (pulse_i) run_len_q <= run_len_q + 1'b1;
            else         run_len_q <= '0;
        end
    end

    // Compare the measured length when the pulse has ended
    always_ff @(posedge clk_i) begin
        if (rst_n_i && !pulse_i && run_len_q != '0)
            AST_PULSE_LENGTH: assert (run_len_q == want_len_q); // R4
    end

    AST_RESET_QUIET: assert property (@(posedge clk_i)
        !rst_n_i |=> (!pulse_i && !overrun_i)); // R1

    AST_START_RAISES: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (start_i && !pulse_i) |=> pulse_i); // R3

    AST_RISE_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(pulse_i) |-> $past(start_i)); // R3

    AST_BUSY_START_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (start_i && pulse_i) |=> overrun_i); // R7

    AST_OVERRUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        overrun_i |=> overrun_i); // R8
endmodule

bind pulse_stretch pulse_stretch_chk #(
    .CNT_W     (CNT_W),
    .DEF_WIDTH (DEF_WIDTH)
) u_chk (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .start_i     (start_w),
    .width_cfg_i (width_cfg_i),
    .pulse_i     (pulse_o),
    .overrun_i   (overrun_o)
);

// File: tb/pulse_stretch_tb.sv
`timescale 1ns/100ps
module pulse_stretch_tb;
    localparam int CNT_W = 9;
    localparam int DEF_W = 240;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             strobe = 1'b0;
    logic [CNT_W-1:0] wcfg = '0;
    logic             pulse;
    logic             ovr;

    int  errs = 0;
    int  checks = 0;
    bit  done = 1'b0;
    bit  ovr_exp = 1'b0;

    pulse_stretch u_dut (
        .clk_i       (clk),
        .rst_n_i     (rst_n),
        .strobe_i    (strobe),
        .width_cfg_i (wcfg),
        .pulse_o     (pulse),
        .overrun_o   (ovr)
    );

    always #2 clk = ~clk;

    function automatic int exp_width(int cfg);
        return (cfg == 0) ? DEF_W : cfg;
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Raise the strobe now and drop it after tenths*0.1 ns
    task automatic fire(int tenths);
        strobe = 1'b1;
        fork
            begin
                #(tenths * 0.1);
                strobe = 1'b0;
            end
        join_none
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    // One strobe, latency and length checks, optional second strobe at inject
    task automatic run_pulse(int cfg, int inject, int tenths, int newcfg, string req);
        int cnt;
        @(posedge clk); #1;
        wcfg = CNT_W'(cfg);
        fire(tenths);
        @(posedge clk); @(posedge clk); #1;
        chk(pulse == 1'b0, "R3 low after E2", pulse, 0);
        @(posedge clk); #1;
        chk(pulse == 1'b1, {req, " R2 R3 high after E3"}, pulse, 1);
        cnt = 1;
        while (cnt < exp_width(cfg) + 20) begin
            if (cnt == 2) wcfg = CNT_W'(newcfg);
            if (inject != 0 && cnt == inject) begin
                fire(5);
                ovr_exp = 1'b1;
            end
            @(posedge clk); #1;
            if (!pulse) break;
            cnt++;
        end
        chk(cnt == exp_width(cfg), {req, " R4 width"}, cnt, exp_width(cfg));
        idle(12); #1;
        chk(pulse == 1'b0, "R9 no second pulse", pulse, 0);
        chk(ovr == ovr_exp, "R7 R8 overrun", ovr, ovr_exp);
    endtask

    task automatic do_reset(bit strobe_in_reset);
        @(posedge clk); #1;
        rst_n = 1'b0;
        idle(2); #1;
        if (strobe_in_reset) fire(5);
        idle(4); #1;
        rst_n = 1'b1;
        ovr_exp = 1'b0;
        idle(10); #1;
        chk(pulse == 1'b0, "R1 R10 pulse after reset", pulse, 0);
        chk(ovr == 1'b0, "R1 overrun after reset", ovr, 0);
    endtask

    initial begin
        int cfg, ncfg, inj, len;
        void'($urandom(32'd20240611));
        idle(3); #1;
        chk(pulse == 1'b0, "R1 pulse in reset", pulse, 0);
        chk(ovr == 1'b0, "R1 overrun in reset", ovr, 0);
        do_reset(1'b1);                            // R10
        run_pulse(10, 0, 5, 10, "R2 sliver");      // R2
        run_pulse(0, 0, 20, 0, "R5 default");      // R5
        run_pulse(1, 0, 30, 1, "R4 min");          // R4
        run_pulse(511, 0, 30, 511, "R4 max");      // R4
        run_pulse(7, 0, 200, 7, "R9 wide");        // R9
        run_pulse(20, 0, 10, 3, "R6 late cfg");    // R6
        run_pulse(30, 10, 10, 30, "R7 overrun");   // R7
        run_pulse(12, 0, 10, 12, "R8 sticky");     // R8
        do_reset(1'b0);                            // R1 clears R8 flag
        for (int t = 0; t < 24; t++) begin
            cfg  = int'($urandom_range(0, 400));
            ncfg = int'($urandom_range(0, 511));
            len  = int'($urandom_range(2, 400));
            inj  = 0;
            if (exp_width(cfg) >= 14 && $urandom_range(0, 3) == 0)
                inj = int'($urandom_range(6, exp_width(cfg) - 4));
            run_pulse(cfg, inj, len, ncfg, "random");
            if (t == 12) do_reset(1'b1);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule